// File: doc/BRIEF.md
# DMA Channel Interrupt and Completion Status Bank

This block holds two per-channel bitmaps for a multi-channel DMA engine. The first is the interrupt-request map. The second is the transfer-completion (done) map. Each cycle the transfer engine presents a vector of completion pulses, one bit per channel, together with the matching per-channel "interrupt on completion" flags taken from the descriptors. A completion always marks the channel done. It raises the channel's interrupt request only when the descriptor asked for one. The interrupt map drives the interrupt controller directly.

Software reaches the bank through a word-wide register port. Writes are single-cycle strobes, and reads are combinational with no side effects. There are two ways to drop interrupt requests. The first is a write-one-to-clear write to the interrupt map. The second is a byte-wide indexed command that names one channel or all channels, so one request can be cleared without a read-modify-write. A second command register of the same form clears done bits. In both command bytes, bit 7 is ignored and bit 6 selects clear-all. When bit 6 is zero, the low bits give the channel number, and any nonzero value in the bits between the two makes the command do nothing. A completion that lands in the same cycle as a clear of the same bit wins, so no event is lost.

Top module: `dma_irq_bank`

## Requirements
- R1: After reset, every interrupt bit and every done bit is 0, `irqOut` is 0 and both maps read back as 0.
- R2: A completion pulse on channel n with its interrupt flag set makes interrupt bit n equal to 1 from the next clock edge.
- R3: A completion pulse on channel n sets done bit n from the next clock edge, whatever its interrupt flag is. With the flag clear, the interrupt bit is left unchanged.
- R4: A write to offset 0x24 clears each interrupt bit whose write-data bit (bit n for channel n) is 1 and leaves the others unchanged.
- R5: A write to offset 0x30 whose data byte has bit 6 = 0 and bits 5:4 = 0 clears only the interrupt bit of the channel given by bits 3:0.
- R6: In both command bytes, values with bit 6 = 0 and bits 5:4 nonzero (16 to 63) change nothing, and bit 7 is ignored.
- R7: A write to offset 0x30 whose data byte has bit 6 = 1 clears all interrupt bits.
- R8: A write to offset 0x34 decodes its data byte as in R5 to R7 but acts on the done bits: it clears one done bit, changes nothing, or clears all done bits.
- R9: When a completion sets a bit in the same cycle as any clear of that same bit, the bit ends as 1.
- R10: A read of offset 0x24 returns the interrupt map and a read of 0x28 returns the done map. In both, bit n holds channel n and bits 31:16 are 0. Other offsets read as 0. A write to 0x28 changes nothing.
- R11: `irqOut` bit n equals interrupt bit n in every cycle, and each change appears at the same edge as the register change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| doneEvt | input | 16 | Per-channel completion pulse from the transfer engine |
| doneIntEn | input | 16 | Per-channel interrupt-on-completion flag from the descriptor |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| irqOut | output | 16 | Interrupt request lines to the interrupt controller |

## Verification
The bench builds the block with its default parameters: 16 channels, an 8-bit offset, a 32-bit data word and an 8-bit command byte. With these values every command decode range can be reached from a single data byte: a single channel (0 to 15), the reserved band (16 to 63), clear-all (64 to 127) and the ignored top bit. The upper half of the word can then be checked as zero on readback. Since all sixteen channels fit in one word, one W1C write and one map read cover every channel. This also lets the bench hit same-cycle set and clear collisions on chosen channels.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  // Register byte offsets
  localparam logic [7:0] OFF_INT_MAP  = 8'h24;
  localparam logic [7:0] OFF_DONE_MAP = 8'h28;
  localparam logic [7:0] OFF_INT_CMD  = 8'h30;
  localparam logic [7:0] OFF_DONE_CMD = 8'h34;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic intW1c;
    logic intClrOne;
    logic intClrAll;
    logic doneClrOne;
    logic doneClrAll;
  } bank_strobe_t;

endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CMD_W  = 8,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_CH-1:0] intMap,
  input  logic [NUM_CH-1:0] doneMap,
  output bank_strobe_t      strobe,
  output logic [IDX_W-1:0]  cmdIdx,
  output logic [NUM_CH-1:0] w1cMask,
  output logic [DATA_W-1:0] rdData
);

  localparam int ALL_BIT = CMD_W - 2;

  logic [ALL_BIT-1:0] cmdLow;
  logic               cmdAll;
  logic               cmdGap;
  logic               cmdOne;
  logic               hitIntMap;
  logic               hitIntCmd;
  logic               hitDoneCmd;
  logic               unusedHigh;

  assign cmdLow = wrData[ALL_BIT-1:0];
  assign cmdAll = wrData[ALL_BIT];
  // Bits between the channel index and the clear-all bit mark a reserved value.
  assign cmdGap = |(cmdLow >> IDX_W);
  assign cmdOne = !cmdAll && !cmdGap;
  assign cmdIdx = wrData[IDX_W-1:0];
  assign w1cMask = wrData[NUM_CH-1:0];
  assign unusedHigh = ^wrData[DATA_W-1:NUM_CH];

  assign hitIntMap  = wrEn && (addr == ADDR_W'(OFF_INT_MAP));
  assign hitIntCmd  = wrEn && (addr == ADDR_W'(OFF_INT_CMD));
  assign hitDoneCmd = wrEn && (addr == ADDR_W'(OFF_DONE_CMD));

  always_comb begin
    strobe = '0;
    strobe.intW1c     = hitIntMap;
    strobe.intClrOne  = hitIntCmd && cmdOne;
    strobe.intClrAll  = hitIntCmd && cmdAll;
    strobe.doneClrOne = hitDoneCmd && cmdOne;
    strobe.doneClrAll = hitDoneCmd && cmdAll;
  end

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(OFF_INT_MAP))       rdData[NUM_CH-1:0] = intMap;
    else if (addr == ADDR_W'(OFF_DONE_MAP)) rdData[NUM_CH-1:0] = doneMap;
  end

  // R6: a single write produces at most one strobe
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  // R6: reserved command values raise no clear strobe
  p_reserved_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cmdGap && !cmdAll) |->
      !(strobe.intClrOne || strobe.intClrAll || strobe.doneClrOne || strobe.doneClrAll));

endmodule

// File: rtl/dma_irq_datapath.sv
module dma_irq_datapath
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] doneEvt,
  input  logic [NUM_CH-1:0] doneIntEn,
  input  bank_strobe_t      strobe,
  input  logic [IDX_W-1:0]  cmdIdx,
  input  logic [NUM_CH-1:0] w1cMask,
  output logic [NUM_CH-1:0] intMap,
  output logic [NUM_CH-1:0] doneMap
);

  logic [NUM_CH-1:0] intSet;
  logic [NUM_CH-1:0] intClr;
  logic [NUM_CH-1:0] doneClr;

  assign intSet = doneEvt & doneIntEn;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic idxHit;
    assign idxHit = (cmdIdx == IDX_W'(ch));
    assign intClr[ch]  = (strobe.intW1c && w1cMask[ch]) || strobe.intClrAll ||
                         (strobe.intClrOne && idxHit);
    assign doneClr[ch] = strobe.doneClrAll || (strobe.doneClrOne && idxHit);

    // A set in the same cycle as a clear leaves the bit at 1.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        intMap[ch]  <= 1'b0;
        doneMap[ch] <= 1'b0;
      end else begin
        intMap[ch]  <= (intMap[ch] && !intClr[ch]) || intSet[ch];
        doneMap[ch] <= (doneMap[ch] && !doneClr[ch]) || doneEvt[ch];
      end
    end
  end

  // R2 and R9: a requested completion always leaves its interrupt bit set
  p_int_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((intMap & $past(intSet)) == $past(intSet)));

  // R3: every completion leaves its done bit set
  p_done_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((doneMap & $past(doneEvt)) == $past(doneEvt)));

  // R3: an interrupt bit rises only with a requested completion
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((intMap & ~$past(intMap) & ~$past(intSet)) == '0));

  // R4: written ones without a competing set are cleared
  p_w1c_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.intW1c |=> ((intMap & $past(w1cMask & ~intSet)) == '0));

  // R7: clear-all leaves only bits set in the same cycle
  p_clr_all_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.intClrAll |=> ((intMap & ~$past(intSet)) == '0));

  // R8: done clear-all leaves only bits completed in the same cycle
  p_done_all_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doneClrAll |=> ((doneMap & ~$past(doneEvt)) == '0));

endmodule

// File: rtl/dma_irq_bank.sv
module dma_irq_bank
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CMD_W  = 8,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] doneEvt,
  input  logic [NUM_CH-1:0] doneIntEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [NUM_CH-1:0] irqOut
);

  bank_strobe_t      strobe;
  logic [IDX_W-1:0]  cmdIdx;
  logic [NUM_CH-1:0] w1cMask;
  logic [NUM_CH-1:0] intMap;
  logic [NUM_CH-1:0] doneMap;

  dma_irq_ctrl #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr), .wrData(regWrData),
    .intMap(intMap), .doneMap(doneMap), .strobe(strobe), .cmdIdx(cmdIdx),
    .w1cMask(w1cMask), .rdData(regRdData)
  );

  dma_irq_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .doneEvt(doneEvt), .doneIntEn(doneIntEn),
    .strobe(strobe), .cmdIdx(cmdIdx), .w1cMask(w1cMask),
    .intMap(intMap), .doneMap(doneMap)
  );

  // R11: interrupt lines follow the map with no qualification
  assign irqOut = intMap;

endmodule

// File: tb/tb_dma_irq_bank.sv
module tb_dma_irq_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] doneEvt = '0;
  logic [15:0] doneIntEn = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [15:0] irqOut;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_bank dut (
    .clk(clk), .rstN(rstN), .doneEvt(doneEvt), .doneIntEn(doneIntEn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  // isWr, addr, data, evt, intEn, expected int map, expected done map
  typedef struct packed {
    logic        isWr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [15:0] evt;
    logic [15:0] en;
    logic [15:0] expInt;
    logic [15:0] expDone;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 32'h0,         16'h0005, 16'h0001, 16'h0001, 16'h0005}, // R2 R3
    '{1'b0, 8'h00, 32'h0,         16'h8F00, 16'hFF00, 16'h8F01, 16'h8F05}, // R2
    '{1'b1, 8'h24, 32'hFFFF0F01,  16'h0,    16'h0,    16'h8000, 16'h8F05}, // R4
    '{1'b0, 8'h00, 32'h0,         16'h00F0, 16'h00F0, 16'h80F0, 16'h8FF5}, // R2
    '{1'b1, 8'h30, 32'h05,        16'h0,    16'h0,    16'h80D0, 16'h8FF5}, // R5
    '{1'b1, 8'h30, 32'h2A,        16'h0,    16'h0,    16'h80D0, 16'h8FF5}, // R6
    '{1'b1, 8'h30, 32'h8F,        16'h0,    16'h0,    16'h00D0, 16'h8FF5}, // R6 R5
    '{1'b1, 8'h34, 32'h02,        16'h0,    16'h0,    16'h00D0, 16'h8FF1}, // R8
    '{1'b1, 8'h34, 32'h3F,        16'h0,    16'h0,    16'h00D0, 16'h8FF1}, // R8 R6
    '{1'b1, 8'h30, 32'h40,        16'h0,    16'h0,    16'h0000, 16'h8FF1}, // R7
    '{1'b0, 8'h00, 32'h0,         16'h0003, 16'h0003, 16'h0003, 16'h8FF3}, // R2
    '{1'b1, 8'h34, 32'h7F,        16'h0,    16'h0,    16'h0003, 16'h0000}, // R8
    '{1'b1, 8'h28, 32'hFFFFFFFF,  16'h0,    16'h0,    16'h0003, 16'h0000}, // R10
    '{1'b0, 8'h00, 32'h0,         16'h0100, 16'h0000, 16'h0003, 16'h0100}  // R3
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic checkMaps(input string tag, input logic [15:0] eInt, input logic [15:0] eDone);
    logic [31:0] v;
    check({tag, " R11 irqOut"}, {16'h0, irqOut}, {16'h0, eInt});
    readReg(8'h24, v);
    check({tag, " R10 int map"}, v, {16'h0, eInt});
    readReg(8'h28, v);
    check({tag, " R10 done map"}, v, {16'h0, eDone});
  endtask

  // One cycle of stimulus, then check after the edge that captures it
  task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [15:0] e, input logic [15:0] en);
    @(negedge clk);
    regWrEn = wr; regAddr = a; regWrData = d; doneEvt = e; doneIntEn = en;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0; doneEvt = '0; doneIntEn = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    checkMaps("R1 reset", 16'h0, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    checkMaps("R1 after release", 16'h0, 16'h0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].isWr, VECS[i].addr, VECS[i].data, VECS[i].evt, VECS[i].en);
      checkMaps($sformatf("vector %0d", i), VECS[i].expInt, VECS[i].expDone);
    end

    // R10: unmapped offsets read zero
    readReg(8'h30, v);
    check("R10 unmapped 0x30", v, 32'h0);
    readReg(8'h00, v);
    check("R10 unmapped 0x00", v, 32'h0);

    // R9: W1C on channel 0 collides with a requested completion on channel 0
    step(1'b1, 8'h24, 32'h0003, 16'h0001, 16'h0001);
    checkMaps("R9 w1c collision", 16'h0001, 16'h0101);

    // R9: interrupt clear-all collides with completion on channel 9
    step(1'b1, 8'h30, 32'h40, 16'h0200, 16'h0200);
    checkMaps("R9 clear-all collision", 16'h0200, 16'h0301);

    // R9: single done clear of channel 8 collides with its completion
    step(1'b1, 8'h34, 32'h08, 16'h0100, 16'h0000);
    checkMaps("R9 done single collision", 16'h0200, 16'h0301);

    // R5: index clear on channel 9, other bits untouched
    step(1'b0, 8'h00, 32'h0, 16'h0C00, 16'h0C00);
    step(1'b1, 8'h30, 32'h09, 16'h0, 16'h0);
    checkMaps("R5 single clear ch9", 16'h0C00, 16'h0F01);

    // R6: value 16 on done command is reserved
    step(1'b1, 8'h34, 32'h10, 16'h0, 16'h0);
    checkMaps("R6 done reserved 16", 16'h0C00, 16'h0F01);

    // R1: reset clears everything again
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkMaps("R1 re-reset", 16'h0, 16'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule